// File: doc/BRIEF.md
# MSI Event Queue Writer

This block turns inbound message-signalled interrupts into entries in circular event queues that sit in host memory. Each incoming MSI carries a vector number and a 16-bit data value. A programmable table steers the vector to one of several queues. The block then issues one 32-bit memory write of the data value to the slot that the queue's tail pointer marks, and waits for memory to acknowledge that write. Only after the acknowledge does it advance the tail, and only after that does the queue's interrupt line rise.

Software owns each queue's head pointer. It consumes entries and moves the head forward through a small write port. A queue's interrupt stays high for as long as the head and tail differ. Each queue has 64 slots, so one slot is always kept empty. An MSI aimed at a full queue is held off with backpressure until software frees a slot. MSIs are handled strictly one at a time in arrival order, so the entries of any queue appear in the order they were received.

Top module: `msi_eq_writer`

## Requirements
- R1: After reset, every tail pointer is 0, every interrupt line is low, and no memory write is requested.
- R2: The entry address is the queue's base address plus four times its tail pointer. The written word holds the MSI data in bits 15:0 and zero in bits 31:16.
- R3: Once a memory write is requested, request, address and data stay unchanged until the cycle in which memAck is high. The tail pointer does not move while the write waits.
- R4: A queue's tail advances by exactly one, visibly in the cycle after the acknowledged write, and wraps from 63 to 0. No tail moves at any other time.
- R5: A queue's interrupt rises only after its tail update, never while the entry write is still outstanding.
- R6: A queue's interrupt is high exactly when its head and tail differ. It drops in the cycle after software writes a head equal to the tail.
- R7: A queue is full when (tail+1) mod 64 equals head. An MSI steered to a full queue sees msiReady low and causes no memory write until software moves the head.
- R8: After reset, vector v maps to queue v mod NUM_QUEUES. A write on the map port redirects the chosen vector to the given queue for all later MSIs.
- R9: Only one MSI is in flight at a time. msiReady is low while a memory write is outstanding, and entries are written in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msiValid | input | 1 | An MSI is offered |
| msiVector | input | 6 | Vector number of the offered MSI |
| msiData | input | 16 | Data value of the offered MSI |
| msiReady | output | 1 | The offered MSI is taken at this clock edge |
| mapWe | input | 1 | Write strobe for the vector-to-queue table |
| mapVector | input | 6 | Vector whose table entry is written |
| mapQueue | input | 2 | Queue number to store for that vector |
| headWe | input | 1 | Software head pointer write strobe |
| headQueue | input | 2 | Queue whose head is written |
| headValue | input | 6 | New head pointer value |
| queueBase | input | NUM_QUEUES*32 | Base byte address of each queue, queue q in bits [q*32 +: 32] |
| memReq | output | 1 | Memory write request |
| memAddr | output | 32 | Byte address of the entry |
| memData | output | 32 | Entry word |
| memAck | input | 1 | Memory write completed |
| tailPtr | output | NUM_QUEUES*6 | Tail pointer of each queue, queue q in bits [q*6 +: 6] |
| irq | output | NUM_QUEUES | Per-queue interrupt line |

## Verification
An MSI presented while msiReady is high is taken at that edge. Its memory write request appears in the next cycle and stays up until the acknowledge edge. The tail and the interrupt change in the cycle right after that acknowledge edge. A head write takes effect on the interrupt one cycle after its strobe edge. The bench drives inputs and samples every output on the falling edge. Its memory responder compares address and data against the scoreboard in the cycle it raises memAck, before the tail is allowed to move. It reads tail pointers and interrupt lines only after the bus has gone idle again.

// File: rtl/msi_eq_pkg.sv
package msi_eq_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic accept;   // capture the offered MSI
    logic tailInc;  // advance the captured queue's tail
  } eqStrobe_t;
endpackage

// File: rtl/msi_eq_ctrl.sv
module msi_eq_ctrl
  import msi_eq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      msiValid,
  input  logic      selFull,
  input  logic      memAck,
  output eqStrobe_t strobe,
  output logic      busy
);
  typedef enum logic {ST_IDLE, ST_WRITE} state_t;
  state_t state;

  always_comb begin
    strobe.accept  = (state == ST_IDLE) && msiValid && !selFull;
    strobe.tailInc = (state == ST_WRITE) && memAck;
    busy           = (state == ST_WRITE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:  if (strobe.accept) state <= ST_WRITE;
        ST_WRITE: if (memAck)        state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msi_eq_datapath.sv
module msi_eq_datapath
  import msi_eq_pkg::*;
#(
  parameter int NUM_QUEUES  = 4,
  parameter int NUM_VECTORS = 64,
  parameter int QUEUE_DEPTH = 64,
  parameter int ADDR_W      = 32,
  parameter int MSI_DATA_W  = 16,
  parameter int ENTRY_W     = 32,
  localparam int QW = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1,
  localparam int VW = $clog2(NUM_VECTORS),
  localparam int PW = $clog2(QUEUE_DEPTH)
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  eqStrobe_t                strobe,
  input  logic [VW-1:0]            msiVector,
  input  logic [MSI_DATA_W-1:0]    msiData,
  input  logic                     mapWe,
  input  logic [VW-1:0]            mapVector,
  input  logic [QW-1:0]            mapQueue,
  input  logic                     headWe,
  input  logic [QW-1:0]            headQueue,
  input  logic [PW-1:0]            headValue,
  input  logic [NUM_QUEUES*ADDR_W-1:0] queueBase,
  output logic                     selFull,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [ENTRY_W-1:0]       memData,
  output logic [NUM_QUEUES*PW-1:0] tailPtr,
  output logic [NUM_QUEUES-1:0]    irq
);
  localparam int BYTE_SHIFT = $clog2(ENTRY_W / 8);

  logic [QW-1:0]         mapTable [NUM_VECTORS];
  logic [PW-1:0]         tailArr  [NUM_QUEUES];
  logic [PW-1:0]         headArr  [NUM_QUEUES];
  logic [ADDR_W-1:0]     baseArr  [NUM_QUEUES];
  logic [QW-1:0]         capQueue;
  logic [MSI_DATA_W-1:0] capData;
  logic [QW-1:0]         curQueue;

  // vector steering table
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int v = 0; v < NUM_VECTORS; v++) mapTable[v] <= QW'(v % NUM_QUEUES);
    end else if (mapWe) begin
      mapTable[mapVector] <= mapQueue;
    end
  end

  assign curQueue = mapTable[msiVector];
  assign selFull  = (tailArr[curQueue] + PW'(1)) == headArr[curQueue];

  // captured event
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capQueue <= '0;
      capData  <= '0;
    end else if (strobe.accept) begin
      capQueue <= curQueue;
      capData  <= msiData;
    end
  end

  // per-queue pointers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int q = 0; q < NUM_QUEUES; q++) begin
        tailArr[q] <= '0;
        headArr[q] <= '0;
      end
    end else begin
      if (strobe.tailInc) tailArr[capQueue] <= tailArr[capQueue] + PW'(1);
      if (headWe)         headArr[headQueue] <= headValue;
    end
  end

  generate
    for (genvar g = 0; g < NUM_QUEUES; g++) begin : g_queue
      assign baseArr[g]            = queueBase[g*ADDR_W +: ADDR_W];
      assign tailPtr[g*PW +: PW]   = tailArr[g];
      assign irq[g]                = tailArr[g] != headArr[g];
    end
  endgenerate

  assign memAddr = baseArr[capQueue] + (ADDR_W'(tailArr[capQueue]) << BYTE_SHIFT);
  assign memData = {{(ENTRY_W-MSI_DATA_W){1'b0}}, capData};
endmodule

// File: rtl/msi_eq_writer.sv
module msi_eq_writer
  import msi_eq_pkg::*;
#(
  parameter int NUM_QUEUES  = 4,
  parameter int NUM_VECTORS = 64,
  parameter int QUEUE_DEPTH = 64,
  parameter int ADDR_W      = 32,
  parameter int MSI_DATA_W  = 16,
  parameter int ENTRY_W     = 32,
  localparam int QW = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1,
  localparam int VW = $clog2(NUM_VECTORS),
  localparam int PW = $clog2(QUEUE_DEPTH)
)(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         msiValid,
  input  logic [VW-1:0]                msiVector,
  input  logic [MSI_DATA_W-1:0]        msiData,
  output logic                         msiReady,
  input  logic                         mapWe,
  input  logic [VW-1:0]                mapVector,
  input  logic [QW-1:0]                mapQueue,
  input  logic                         headWe,
  input  logic [QW-1:0]                headQueue,
  input  logic [PW-1:0]                headValue,
  input  logic [NUM_QUEUES*ADDR_W-1:0] queueBase,
  output logic                         memReq,
  output logic [ADDR_W-1:0]            memAddr,
  output logic [ENTRY_W-1:0]           memData,
  input  logic                         memAck,
  output logic [NUM_QUEUES*PW-1:0]     tailPtr,
  output logic [NUM_QUEUES-1:0]        irq
);
  eqStrobe_t strobe;
  logic      selFull;
  logic      busy;

  msi_eq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .msiValid(msiValid), .selFull(selFull),
    .memAck(memAck), .strobe(strobe), .busy(busy)
  );

  msi_eq_datapath #(
    .NUM_QUEUES(NUM_QUEUES), .NUM_VECTORS(NUM_VECTORS), .QUEUE_DEPTH(QUEUE_DEPTH),
    .ADDR_W(ADDR_W), .MSI_DATA_W(MSI_DATA_W), .ENTRY_W(ENTRY_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .msiVector(msiVector), .msiData(msiData),
    .mapWe(mapWe), .mapVector(mapVector), .mapQueue(mapQueue),
    .headWe(headWe), .headQueue(headQueue), .headValue(headValue),
    .queueBase(queueBase), .selFull(selFull),
    .memAddr(memAddr), .memData(memData), .tailPtr(tailPtr), .irq(irq)
  );

  assign memReq   = busy;
  assign msiReady = strobe.accept;
endmodule

// File: rtl/msi_eq_writer_chk.sv
module msi_eq_writer_chk #(
  parameter int NUM_QUEUES = 4,
  parameter int PW         = 6,
  parameter int ADDR_W     = 32,
  parameter int ENTRY_W    = 32,
  parameter int MSI_DATA_W = 16
)(
  input logic                     clk,
  input logic                     rstN,
  input logic                     msiReady,
  input logic                     headWe,
  input logic                     memReq,
  input logic [ADDR_W-1:0]        memAddr,
  input logic [ENTRY_W-1:0]       memData,
  input logic                     memAck,
  input logic [NUM_QUEUES*PW-1:0] tailPtr,
  input logic [NUM_QUEUES-1:0]    irq
);
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memData[ENTRY_W-1:MSI_DATA_W] == '0);

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memData));

  p_tail_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && memAck) |=> $stable(tailPtr));

  p_one_in_flight_r9: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !msiReady);

  generate
    for (genvar g = 0; g < NUM_QUEUES; g++) begin : g_irq
      p_irq_after_tail_r5: assert property (@(posedge clk) disable iff (!rstN)
        $rose(irq[g]) |-> $past(memReq && memAck) || $past(headWe));
    end
  endgenerate
endmodule

bind msi_eq_writer msi_eq_writer_chk #(
  .NUM_QUEUES(NUM_QUEUES), .PW(PW), .ADDR_W(ADDR_W),
  .ENTRY_W(ENTRY_W), .MSI_DATA_W(MSI_DATA_W)
) u_chk (
  .clk(clk), .rstN(rstN), .msiReady(msiReady), .headWe(headWe),
  .memReq(memReq), .memAddr(memAddr), .memData(memData), .memAck(memAck),
  .tailPtr(tailPtr), .irq(irq)
);

// File: tb/msi_eq_writer_test.sv
module msi_eq_writer_test;
  localparam int NQ = 4;
  localparam int PW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msiValid = 1'b0;
  logic [5:0] msiVector = '0;
  logic [15:0] msiData = '0;
  logic msiReady;
  logic mapWe = 1'b0;
  logic [5:0] mapVector = '0;
  logic [1:0] mapQueue = '0;
  logic headWe = 1'b0;
  logic [1:0] headQueue = '0;
  logic [5:0] headValue = '0;
  logic [NQ*32-1:0] queueBase;
  logic memReq;
  logic [31:0] memAddr;
  logic [31:0] memData;
  logic memAck = 1'b0;
  logic [NQ*PW-1:0] tailPtr;
  logic [NQ-1:0] irq;

  always #10 clk = ~clk;

  msi_eq_writer uut (
    .clk(clk), .rstN(rstN), .msiValid(msiValid), .msiVector(msiVector),
    .msiData(msiData), .msiReady(msiReady), .mapWe(mapWe), .mapVector(mapVector),
    .mapQueue(mapQueue), .headWe(headWe), .headQueue(headQueue), .headValue(headValue),
    .queueBase(queueBase), .memReq(memReq), .memAddr(memAddr), .memData(memData),
    .memAck(memAck), .tailPtr(tailPtr), .irq(irq)
  );

  int testCount = 0;
  int failCount = 0;
  int ackDelay = 0;
  int waitCnt = 0;
  int cycles = 0;
  logic [31:0] baseOf [NQ];
  logic [5:0] mTail [NQ];
  logic [5:0] mHead [NQ];

  typedef struct { logic [31:0] addr; logic [31:0] data; int q; logic [5:0] slot; } item_t;
  item_t sb[$];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory responder and scoreboard monitor
  always @(negedge clk) begin
    if (rstN && memReq) begin
      if (msiValid) check("R9 ready low while busy", 64'(msiReady), 64'd0);
      if (waitCnt >= ackDelay) begin
        item_t e;
        if (sb.size() == 0) begin
          check("R9 unexpected write", 64'd1, 64'd0);
        end else begin
          e = sb.pop_front();
          check("R2 entry address", 64'(memAddr), 64'(e.addr));
          check("R2 entry data", 64'(memData), 64'(e.data));
          check("R3 tail held until ack", 64'(tailPtr[e.q*PW +: PW]), 64'(e.slot));
          check("R5 irq not before tail update", 64'(irq[e.q]), 64'(e.slot != mHead[e.q]));
        end
        memAck = 1'b1;
        waitCnt = 0;
      end else begin
        memAck = 1'b0;
        waitCnt++;
      end
    end else begin
      memAck = 1'b0;
      waitCnt = 0;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failCount++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  task automatic pushExp(input logic [15:0] d, input int q);
    item_t e;
    e.addr = baseOf[q] + 32'(mTail[q]) * 4;
    e.data = {16'h0, d};
    e.q = q;
    e.slot = mTail[q];
    sb.push_back(e);
    mTail[q] = mTail[q] + 6'd1;
  endtask

  task automatic sendMsi(input logic [5:0] v, input logic [15:0] d, input int q);
    pushExp(d, q);
    @(negedge clk);
    msiValid = 1'b1; msiVector = v; msiData = d;
    #1;
    while (!msiReady) begin @(negedge clk); #1; end
    @(negedge clk);
    msiValid = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (sb.size() != 0 || memReq) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic writeHead(input int q, input logic [5:0] h);
    @(negedge clk);
    headWe = 1'b1; headQueue = 2'(q); headValue = h;
    @(negedge clk);
    headWe = 1'b0;
    mHead[q] = h;
  endtask

  initial begin
    for (int q = 0; q < NQ; q++) begin
      baseOf[q] = 32'h1000 * (q + 1) + 32'h40;
      queueBase[q*32 +: 32] = baseOf[q];
      mTail[q] = '0;
      mHead[q] = '0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 tails zero", 64'(tailPtr), 64'd0);
    check("R1 irq low", 64'(irq), 64'd0);
    check("R1 no request", 64'(memReq), 64'd0);
    rstN = 1'b1;

    // R8 default steering, R4 tail step, R5 irq after update
    sendMsi(6'd0, 16'h1234, 0);
    waitIdle();
    check("R4 tail q0", 64'(tailPtr[0*PW +: PW]), 64'd1);
    check("R5 irq q0 up", 64'(irq), 64'b0001);

    ackDelay = 3;
    sendMsi(6'd5, 16'hBEEF, 1);   // R8: 5 mod 4 = 1
    waitIdle();
    check("R4 tail q1", 64'(tailPtr[1*PW +: PW]), 64'd1);
    check("R6 irq q0 q1", 64'(irq), 64'b0011);

    // R8 remap vector 5 to queue 3
    @(negedge clk);
    mapWe = 1'b1; mapVector = 6'd5; mapQueue = 2'd3;
    @(negedge clk);
    mapWe = 1'b0;
    sendMsi(6'd5, 16'hA5A5, 3);
    waitIdle();
    check("R8 remapped tail q3", 64'(tailPtr[3*PW +: PW]), 64'd1);
    check("R8 q1 untouched", 64'(tailPtr[1*PW +: PW]), 64'd1);

    // R6 head catches tail
    writeHead(0, 6'd1);
    check("R6 irq q0 dropped", 64'(irq), 64'b1010);

    // R9 back-to-back mixed queues in order
    ackDelay = 1;
    sendMsi(6'd4, 16'h0101, 0);
    sendMsi(6'd1, 16'h0202, 1);
    sendMsi(6'd4, 16'h0303, 0);
    waitIdle();
    check("R9 tail q0", 64'(tailPtr[0*PW +: PW]), 64'd3);

    // R7 fill queue 2, then blocked, then wrap (R4)
    ackDelay = 0;
    for (int i = 0; i < 63; i++) sendMsi(6'd2, 16'(i + 16'h700), 2);
    waitIdle();
    check("R7 tail q2 at 63", 64'(tailPtr[2*PW +: PW]), 64'd63);
    pushExp(16'hF00D, 2);
    @(negedge clk);
    msiValid = 1'b1; msiVector = 6'd2; msiData = 16'hF00D;
    for (int i = 0; i < 5; i++) begin
      #1;
      check("R7 held off when full", 64'({msiReady, memReq}), 64'd0);
      @(negedge clk);
    end
    headWe = 1'b1; headQueue = 2'd2; headValue = 6'd1;
    @(negedge clk);
    headWe = 1'b0;
    mHead[2] = 6'd1;
    #1;
    while (!msiReady) begin @(negedge clk); #1; end
    @(negedge clk);
    msiValid = 1'b0;
    waitIdle();
    check("R4 tail wraps to 0", 64'(tailPtr[2*PW +: PW]), 64'd0);
    check("R6 irq q2 still up", 64'(irq[2]), 64'd1);
    check("R9 scoreboard drained", 64'(sb.size()), 64'd0);

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule